// File: doc/BRIEF.md
# Bus Traffic Meter

The bus traffic meter watches one port of an on-chip bus and adds up the bytes that cross it. On every clock the monitored port presents a byte count for that cycle. While the meter is running, it adds this count to an accumulator. Software programs a limit and reads back the running total through a small word-addressed register bus. Two sticky status flags record events. One records that the total reached the limit. The other records that the accumulator carried out of its top bit. A level interrupt is raised while an enabled flag is pending.

A build-time choice picks how the accumulator behaves at the limit. In the wrapping variant, the total returns to zero each time it reaches the limit, and software adds the limit back when it sees the flag. In the free-running variant, the total only flags the limit crossing and keeps counting until it carries out of its full width. The accumulator width is a parameter, 32 bits by default. Register reads zero-extend it to the data width.

Top module: `bus_traffic_meter`

## Requirements
- R1: After reset the count is 0, both status flags are 0, the run and interrupt-enable bits are 0, the limit holds all ones (CNT_W bits), and `irq` is low.
- R2: Register offsets on `bus_addr` are: run control 0x280 (bit 0), counter clear 0x284, count 0x288, limit 0x290, status 0x100 (bit 0 limit flag, bit 1 carry flag), flag clear 0x108, and interrupt enable 0x10C (bit 0). Count and limit read back zero-extended. The flag-clear and counter-clear offsets, and every other offset, read as zero. A write to the limit stores the low CNT_W data bits.
- R3: While run bit 0 is 1, each rising clock adds `beat_bytes` to the count. While it is 0, the count holds its value and `beat_bytes` is ignored. Writing run takes effect from the edge after the write edge.
- R4: A write of bit 0 = 1 to the counter-clear offset sets the count to zero at that edge. This overrides the addition in the same cycle, whose bytes are discarded and raise no flag.
- R5: Status bit 0 is set when an addition makes the sum reach or pass the limit. In the free-running variant this happens only when the count was below the limit before the addition.
- R6: In the wrapping variant, an addition that reaches or passes the limit leaves the count at 0. The count is never above the limit after an addition, and status bit 1 never sets.
- R7: In the free-running variant, the count keeps the sum modulo 2^CNT_W. An addition that carries out of CNT_W bits sets status bit 1.
- R8: Status bits stay set until a write to 0x108 with a 1 in the matching data bit clears them, bit by bit. A new event in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly when interrupt-enable bit 0 is 1 and at least one status bit is 1.
- R10: Writes to the count offset and to the status offset leave the count and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe for this cycle |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| beat_bytes | input | BYTE_W | Bytes moved on the monitored port in this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The carry flag is the hardest state to reach, because it needs the whole accumulator range to be consumed by byte-sized additions. The count register cannot be loaded from the bus. The bench therefore builds both variants with a 12-bit accumulator, so a short burst of full-size beats carries within a few dozen cycles. The two instances share every input, which makes each stimulus show the wrapping and free-running results side by side. That includes a flag clear written in the very cycle that produces a new limit crossing.

// File: rtl/tm_pkg.sv
package tm_pkg;

  // Register byte offsets; software relies on these positions.
  localparam logic [11:0] OFS_STATUS = 12'h100;
  localparam logic [11:0] OFS_FLGCLR = 12'h108;
  localparam logic [11:0] OFS_IRQEN  = 12'h10C;
  localparam logic [11:0] OFS_RUN    = 12'h280;
  localparam logic [11:0] OFS_CNTCLR = 12'h284;
  localparam logic [11:0] OFS_COUNT  = 12'h288;
  localparam logic [11:0] OFS_LIMIT  = 12'h290;

  // Status flag positions.
  localparam int unsigned FLG_LIMIT = 0;
  localparam int unsigned FLG_CARRY = 1;
  localparam int unsigned FLG_W     = 2;

  typedef logic [FLG_W-1:0] tm_flags_t;

endpackage

// File: rtl/tm_rst_sync.sv
module tm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/tm_regfile.sv
module tm_regfile
  import tm_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  tm_flags_t         flags,
  output logic              run,
  output logic              irq_en,
  output logic [CNT_W-1:0]  limit,
  output logic              cnt_clr,
  output tm_flags_t         flg_clr
);

  logic sel_status, sel_flgclr, sel_irqen, sel_run;
  logic sel_cntclr, sel_count, sel_limit;

  logic             run_q, run_d;
  logic             irq_en_q, irq_en_d;
  logic [CNT_W-1:0] limit_q, limit_d;

  // Address decode
  always_comb begin
    sel_status = (bus_addr == ADDR_W'(OFS_STATUS));
    sel_flgclr = (bus_addr == ADDR_W'(OFS_FLGCLR));
    sel_irqen  = (bus_addr == ADDR_W'(OFS_IRQEN));
    sel_run    = (bus_addr == ADDR_W'(OFS_RUN));
    sel_cntclr = (bus_addr == ADDR_W'(OFS_CNTCLR));
    sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
    sel_limit  = (bus_addr == ADDR_W'(OFS_LIMIT));
  end

  // Next state of the control registers
  always_comb begin
    run_d    = run_q;
    irq_en_d = irq_en_q;
    limit_d  = limit_q;
    if (bus_wr) begin
      if (sel_run)   run_d    = bus_wdata[0];
      if (sel_irqen) irq_en_d = bus_wdata[0];
      if (sel_limit) limit_d  = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
      limit_q  <= '1;
    end else begin
      run_q    <= run_d;
      irq_en_q <= irq_en_d;
      limit_q  <= limit_d;
    end
  end

  // Single-cycle command pulses
  always_comb begin
    cnt_clr = bus_wr && sel_cntclr && bus_wdata[0];
    flg_clr = (bus_wr && sel_flgclr) ? bus_wdata[FLG_W-1:0] : '0;
  end

  // Read mux; clear offsets and holes read zero
  always_comb begin
    bus_rdata = '0;
    if (sel_status)     bus_rdata = DATA_W'(flags);
    else if (sel_irqen) bus_rdata = DATA_W'(irq_en_q);
    else if (sel_run)   bus_rdata = DATA_W'(run_q);
    else if (sel_count) bus_rdata = DATA_W'(count);
    else if (sel_limit) bus_rdata = DATA_W'(limit_q);
  end

  assign run    = run_q;
  assign irq_en = irq_en_q;
  assign limit  = limit_q;

endmodule

// File: rtl/tm_accum.sv
module tm_accum #(
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned BYTE_W        = 8,
  parameter bit          WRAP_AT_LIMIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cnt_clr,
  input  logic [BYTE_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]  limit,
  output logic [CNT_W-1:0]  count,
  output logic              hit,
  output logic              carry
);

  localparam int unsigned SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] count_q, count_d;
  logic [SUM_W-1:0] sum;
  logic             reach;
  logic [CNT_W-1:0] step_val;
  logic             step_hit;
  logic             step_carry;

  always_comb begin
    sum   = {1'b0, count_q} + SUM_W'(beat_bytes);
    reach = (sum >= {1'b0, limit});
  end

  generate
    if (WRAP_AT_LIMIT) begin : g_wrap
      always_comb begin
        step_hit   = reach;
        step_carry = 1'b0;
        step_val   = reach ? '0 : sum[CNT_W-1:0];
      end
    end else begin : g_free
      always_comb begin
        step_hit   = reach && (count_q < limit);
        step_carry = sum[CNT_W];
        step_val   = sum[CNT_W-1:0];
      end
    end
  endgenerate

  // Clear overrides accumulation; stopped counter holds.
  always_comb begin
    count_d = count_q;
    hit     = 1'b0;
    carry   = 1'b0;
    if (cnt_clr) begin
      count_d = '0;
    end else if (run) begin
      count_d = step_val;
      hit     = step_hit;
      carry   = step_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/tm_flags.sv
module tm_flags
  import tm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  logic      carry,
  input  tm_flags_t flg_clr,
  input  logic      irq_en,
  output tm_flags_t flags,
  output logic      irq
);

  tm_flags_t flags_q, flags_d, events;

  always_comb begin
    events            = '0;
    events[FLG_LIMIT] = hit;
    events[FLG_CARRY] = carry;
    // New event wins over a clear in the same cycle.
    flags_d = (flags_q & ~flg_clr) | events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_en && (|flags_q);

endmodule

// File: rtl/bus_traffic_meter.sv
module bus_traffic_meter
  import tm_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned BYTE_W        = 8,
  parameter bit          WRAP_AT_LIMIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] beat_bytes,
  output logic              irq
);

  logic             rst_q_n;
  logic             run_w, ien_w, cnt_clr_w, hit_w, carry_w;
  logic [CNT_W-1:0] count_w, limit_w;
  tm_flags_t        flags_w, flg_clr_w;

  tm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  tm_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count     (count_w),
    .flags     (flags_w),
    .run       (run_w),
    .irq_en    (ien_w),
    .limit     (limit_w),
    .cnt_clr   (cnt_clr_w),
    .flg_clr   (flg_clr_w)
  );

  tm_accum #(
    .CNT_W         (CNT_W),
    .BYTE_W        (BYTE_W),
    .WRAP_AT_LIMIT (WRAP_AT_LIMIT)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .run        (run_w),
    .cnt_clr    (cnt_clr_w),
    .beat_bytes (beat_bytes),
    .limit      (limit_w),
    .count      (count_w),
    .hit        (hit_w),
    .carry      (carry_w)
  );

  tm_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .hit     (hit_w),
    .carry   (carry_w),
    .flg_clr (flg_clr_w),
    .irq_en  (ien_w),
    .flags   (flags_w),
    .irq     (irq)
  );

endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int unsigned CNT_W         = 32,
  parameter bit          WRAP_AT_LIMIT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cnt_clr,
  input logic [1:0]       flg_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic [1:0]       flags
);

  // R3: a stopped meter keeps its count
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr) |=> $stable(count));

  // R4: counter clear lands as zero
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));

  // R8: flags persist until their clear bit is written
  a_r8_limit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flg_clr[0]) |=> flags[0]);

  a_r8_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flg_clr[1]) |=> flags[1]);

  generate
    if (WRAP_AT_LIMIT) begin : g_wrap_chk
      // R6: wrapping keeps the count at or below the limit in force
      a_r6_wrap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_clr) |=> (count <= $past(limit)));

      // R6: carry flag never appears in the wrapping variant
      a_r6_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[1]);
    end else begin : g_free_chk
      // R7: a carry flag only rises while counting
      a_r7_carry_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(run));
    end
  endgenerate

endmodule

bind bus_traffic_meter tm_checker #(
  .CNT_W         (CNT_W),
  .WRAP_AT_LIMIT (WRAP_AT_LIMIT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_w),
  .cnt_clr (cnt_clr_w),
  .flg_clr (flg_clr_w),
  .count   (count_w),
  .limit   (limit_w),
  .flags   (flags_w)
);

// File: tb/bus_traffic_meter_bench.sv
module bus_traffic_meter_bench;

  localparam int unsigned CW = 12;

  localparam logic [11:0] A_STATUS = 12'h100;
  localparam logic [11:0] A_FLGCLR = 12'h108;
  localparam logic [11:0] A_IRQEN  = 12'h10C;
  localparam logic [11:0] A_RUN    = 12'h280;
  localparam logic [11:0] A_CNTCLR = 12'h284;
  localparam logic [11:0] A_COUNT  = 12'h288;
  localparam logic [11:0] A_LIMIT  = 12'h290;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [7:0]  beat_bytes;
  logic [31:0] rdata_f, rdata_w;
  logic        irq_f, irq_w;

  typedef struct {
    string       tag;
    logic [31:0] exp_f;
    logic [31:0] exp_w;
    bit          chk_irq;
    bit          irq_f;
    bit          irq_w;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   mon_go   = 1'b0;
  bit   done     = 1'b0;

  bus_traffic_meter #(.CNT_W(CW), .WRAP_AT_LIMIT(1'b0)) u_bus_traffic_meter (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (rdata_f), .beat_bytes (beat_bytes),
    .irq (irq_f)
  );

  bus_traffic_meter #(.CNT_W(CW), .WRAP_AT_LIMIT(1'b1)) u_bus_traffic_meter_wrap (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (rdata_w), .beat_bytes (beat_bytes),
    .irq (irq_w)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      compare(cur.tag, "free rdata", rdata_f, cur.exp_f);
      compare(cur.tag, "wrap rdata", rdata_w, cur.exp_w);
      if (cur.chk_irq) begin
        compare(cur.tag, "free irq", {31'b0, irq_f}, {31'b0, cur.irq_f});
        compare(cur.tag, "wrap irq", {31'b0, irq_w}, {31'b0, cur.irq_w});
      end
    end
  end

  task automatic expect_rd(string tag, logic [11:0] a, logic [31:0] ef, logic [31:0] ew,
                           bit ci = 1'b0, bit i_f = 1'b0, bit i_w = 1'b0);
    exp_t it;
    it.tag = tag; it.exp_f = ef; it.exp_w = ew;
    it.chk_irq = ci; it.irq_f = i_f; it.irq_w = i_w;
    bus_addr = a;
    exp_q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk);
    #1 mon_go = 1'b0;
    bus_addr = '0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic wr_beats(logic [11:0] a, logic [31:0] d, logic [7:0] b);
    beat_bytes = b;
    wr(a, d);
    beat_bytes = '0;
  endtask

  task automatic feed(logic [7:0] b, int n);
    beat_bytes = b;
    repeat (n) @(posedge clk);
    #1 beat_bytes = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; beat_bytes = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: reset state
    expect_rd("R1 status", A_STATUS, 0, 0, 1'b1, 1'b0, 1'b0);
    expect_rd("R1 count",  A_COUNT,  0, 0);
    expect_rd("R1 limit",  A_LIMIT,  32'hFFF, 32'hFFF);
    expect_rd("R1 irqen",  A_IRQEN,  0, 0);
    expect_rd("R1 run",    A_RUN,    0, 0);

    // R2: limit read-back
    wr(A_LIMIT, 32'd100);
    expect_rd("R2 limit", A_LIMIT, 100, 100);

    // R3: bytes ignored while stopped
    feed(8'd5, 4);
    expect_rd("R3 stopped", A_COUNT, 0, 0);

    // R3: accumulation while running
    wr(A_RUN, 32'd1);
    expect_rd("R2 run", A_RUN, 1, 1);
    feed(8'd10, 5);
    expect_rd("R3 sum", A_COUNT, 50, 50);
    expect_rd("R5 below", A_STATUS, 0, 0);

    // R3: hold after stop; R10: count write ignored
    wr(A_RUN, 32'd0);
    feed(8'd7, 3);
    wr(A_COUNT, 32'd123);
    expect_rd("R10 count", A_COUNT, 50, 50);

    // R5/R6: limit crossing
    wr(A_RUN, 32'd1);
    feed(8'd30, 2);
    expect_rd("R6 count", A_COUNT, 110, 0);
    expect_rd("R5 flag", A_STATUS, 1, 1, 1'b1, 1'b0, 1'b0);

    // R9: enable gates irq
    wr(A_IRQEN, 32'd1);
    expect_rd("R9 irq on", A_STATUS, 1, 1, 1'b1, 1'b1, 1'b1);

    // R10: status write ignored
    wr(A_STATUS, 32'd3);
    expect_rd("R10 status", A_STATUS, 1, 1, 1'b1, 1'b1, 1'b1);

    // R8: clear
    wr(A_FLGCLR, 32'd1);
    expect_rd("R8 cleared", A_STATUS, 0, 0, 1'b1, 1'b0, 1'b0);

    // R5: no re-flag when already above the limit (free variant)
    feed(8'd20, 1);
    expect_rd("R5 no recross", A_STATUS, 0, 0);
    expect_rd("R5 count", A_COUNT, 130, 20);

    // R4: counter clear
    wr(A_CNTCLR, 32'd1);
    expect_rd("R4 clear", A_COUNT, 0, 0);

    // R7: carry out of 12 bits
    wr(A_LIMIT, 32'd4000);
    expect_rd("R2 limit2", A_LIMIT, 4000, 4000);
    feed(8'd250, 16);
    feed(8'd100, 1);
    expect_rd("R7 count", A_COUNT, 4, 100);
    expect_rd("R7 flags", A_STATUS, 3, 1, 1'b1, 1'b1, 1'b1);

    // R8: per-bit clear
    wr(A_FLGCLR, 32'd2);
    expect_rd("R8 bit1 only", A_STATUS, 1, 1);
    wr(A_FLGCLR, 32'd3);
    expect_rd("R8 both", A_STATUS, 0, 0, 1'b1, 1'b0, 1'b0);

    // R8: event in the clear cycle wins
    wr(A_LIMIT, 32'd200);
    wr_beats(A_FLGCLR, 32'd3, 8'd200);
    expect_rd("R8 event wins", A_STATUS, 1, 1, 1'b1, 1'b1, 1'b1);
    expect_rd("R8 count", A_COUNT, 204, 0);

    // R4: clear overrides same-cycle bytes
    wr_beats(A_CNTCLR, 32'd1, 8'd9);
    expect_rd("R4 override", A_COUNT, 0, 0);
    expect_rd("R4 flags kept", A_STATUS, 1, 1);

    // R9: disable irq with flags pending
    wr(A_IRQEN, 32'd0);
    expect_rd("R9 irq off", A_IRQEN, 0, 0, 1'b1, 1'b0, 1'b0);

    // R2: zero-reading offsets
    expect_rd("R2 hole",   12'h004,  0, 0);
    expect_rd("R2 flgclr", A_FLGCLR, 0, 0);
    expect_rd("R2 cntclr", A_CNTCLR, 0, 0);

    repeat (2) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule